// File: doc/BRIEF.md
# Serial Reconfiguration Request Register

This block is a control register that a host reaches over a serial link. It decides which of two configuration images the device should boot from next. A 41-bit shift chain sits between the serial pins and a 39-bit hold register. The upper two bits of the chain form a capture selector. The lower 39 bits carry data in and out. Two mode inputs pick the operation on each clock edge:

- **Shift:** one bit enters at the top of the data field and one leaves at the bottom.
- **Capture:** the data field is loaded from one of four words chosen by the selector. These are a live status word, two saved status words zero-padded to 39 bits, or the hold register itself.
- **Update:** the hold register is copied from the data field.

In a typical sequence the host captures a status word and shifts it out on the serial output while shifting a new request in. It then pulses update so the request lands in the hold register. Only the low 14 bits of the hold register are stored. The rest are reserved and always read back as zero.

Bit 12 of the hold register is an override enable and bit 13 is an image number. A registered decode stage turns these, together with an external image-select pin, into the image-select output that reconfiguration sequencing would use. The selector bits are loaded from a separate 2-bit input under a strobe that is honoured only in update mode. All registers use one clock and a synchronous active-high reset.

Top module: `cfg_scu_reg`

## Requirements
- R1: With shift_en=1, each rising edge moves chain bits [38:0] to {ser_in, chain[38:1]}, whatever the value of capt_en. ser_out always shows chain bit 0, so the bit shifted in first appears at ser_out after 39 shifts.
- R2: While shift_en=1, neither the hold register nor the capture selector changes, even when sel_wr is high.
- R3: With shift_en=0 and capt_en=0 (update), a rising edge copies chain bits [13:0] into the hold register.
- R4: With shift_en=0 and capt_en=1 (capture), a rising edge loads chain bits [38:0] according to the selector:
  - 00 gives cur_state.
  - 01 gives {8'b0, prev_app1}.
  - 10 gives {8'b0, prev_app2}.
  - 11 gives the hold register contents.
- R5: Hold register bits [38:14] are reserved. A capture with selector 11 always returns them as zero, whatever was shifted in at those positions before an update.
- R6: sel_wr writes sel_data into the selector on a rising edge only in update mode. In capture or shift mode the strobe has no effect.
- R7: One edge after the hold register changes:
  - img_ovr shows hold bit 12.
  - img_sel shows hold bit 13 when hold bit 12 is 1, and otherwise shows pin_img_sel.
  - A change on pin_img_sel reaches img_sel one edge later.
- R8: A synchronous reset clears the chain, the selector (to 00), the hold register and the decoded outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | 1 selects shift; 0 selects capture or update |
| capt_en | input | 1 | When shift_en=0: 1 selects capture, 0 selects update |
| ser_in | input | 1 | Serial data entering chain bit 38 |
| sel_wr | input | 1 | Strobe that writes the capture selector (update mode only) |
| sel_data | input | 2 | New capture selector value |
| cur_state | input | 39 | Live status word |
| prev_app1 | input | 31 | First saved status word |
| prev_app2 | input | 31 | Second saved status word |
| pin_img_sel | input | 1 | External image-select pin |
| ser_out | output | 1 | Chain bit 0 |
| img_sel | output | 1 | Effective image number, registered |
| img_ovr | output | 1 | Registered override-enable bit |

## Verification
A wrong bit in the shift chain shows up as a wrong bit on ser_out once enough shifts have moved it to bit 0. That takes at most 38 edges after the capture or shift that corrupted it.

A corrupted selector or hold register stays hidden until the next capture reads it back. The exception is hold bits 12 and 13, which reach img_ovr and img_sel one edge after the hold register changes. For this reason every scenario ends with a capture followed by a full 39-bit read-out, and the image tests sample the decoded outputs exactly one edge after each update.

// File: rtl/cfg_scu_pkg.sv
package cfg_scu_pkg;

  typedef enum logic [1:0] {
    SRC_CUR   = 2'b00,
    SRC_PREV1 = 2'b01,
    SRC_PREV2 = 2'b10,
    SRC_HOLD  = 2'b11
  } cap_src_e;

  typedef enum logic [1:0] {
    OP_UPDATE  = 2'b00,
    OP_CAPTURE = 2'b01,
    OP_SHIFT   = 2'b10
  } op_e;

  function automatic op_e decode_op(input logic shift_en, input logic capt_en);
    if (shift_en)     return OP_SHIFT;
    else if (capt_en) return OP_CAPTURE;
    else              return OP_UPDATE;
  endfunction

endpackage

// File: rtl/cfg_scu_shift.sv
module cfg_scu_shift
  import cfg_scu_pkg::*;
#(
  parameter int DATA_W = 39,
  parameter int PREV_W = 31,
  parameter int HOLD_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  op_e               op,
  input  logic              ser_in,
  input  logic              sel_wr,
  input  logic [1:0]        sel_data,
  input  logic [DATA_W-1:0] cur_state,
  input  logic [PREV_W-1:0] prev_app1,
  input  logic [PREV_W-1:0] prev_app2,
  input  logic [HOLD_W-1:0] hold_q,
  output logic [DATA_W-1:0] data_q,
  output cap_src_e          src_q
);

  localparam int PAD_W  = DATA_W - PREV_W;
  localparam int RSVD_W = DATA_W - HOLD_W;

  logic [DATA_W-1:0] cap_word;

  // Source multiplexer for capture; saved words are zero-padded on top.
  always_comb begin
    unique case (src_q)
      SRC_CUR:   cap_word = cur_state;
      SRC_PREV1: cap_word = {{PAD_W{1'b0}}, prev_app1};
      SRC_PREV2: cap_word = {{PAD_W{1'b0}}, prev_app2};
      default:   cap_word = {{RSVD_W{1'b0}}, hold_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      src_q  <= SRC_CUR;
    end else begin
      unique case (op)
        OP_SHIFT:   data_q <= {ser_in, data_q[DATA_W-1:1]};
        OP_CAPTURE: data_q <= cap_word;
        default: begin
          if (sel_wr) src_q <= cap_src_e'(sel_data);
        end
      endcase
    end
  end

endmodule

// File: rtl/cfg_scu_hold.sv
module cfg_scu_hold
  import cfg_scu_pkg::*;
#(
  parameter int HOLD_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  op_e               op,
  input  logic [HOLD_W-1:0] load_data,
  output logic [HOLD_W-1:0] hold_q
);

  // Only the defined low field is stored; reserved bits have no flops.
  always_ff @(posedge clk) begin
    if (rst)                  hold_q <= '0;
    else if (op == OP_UPDATE) hold_q <= load_data;
  end

endmodule

// File: rtl/cfg_scu_imgsel.sv
module cfg_scu_imgsel (
  input  logic clk,
  input  logic rst,
  input  logic ovr_bit,
  input  logic sel_bit,
  input  logic pin_img_sel,
  output logic img_sel,
  output logic img_ovr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      img_sel <= 1'b0;
      img_ovr <= 1'b0;
    end else begin
      img_sel <= ovr_bit ? sel_bit : pin_img_sel;
      img_ovr <= ovr_bit;
    end
  end

endmodule

// File: rtl/cfg_scu_reg.sv
module cfg_scu_reg
  import cfg_scu_pkg::*;
#(
  parameter int DATA_W  = 39,
  parameter int PREV_W  = 31,
  parameter int HOLD_W  = 14,
  parameter int OVR_BIT = 12,
  parameter int SEL_BIT = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              capt_en,
  input  logic              ser_in,
  input  logic              sel_wr,
  input  logic [1:0]        sel_data,
  input  logic [DATA_W-1:0] cur_state,
  input  logic [PREV_W-1:0] prev_app1,
  input  logic [PREV_W-1:0] prev_app2,
  input  logic              pin_img_sel,
  output logic              ser_out,
  output logic              img_sel,
  output logic              img_ovr
);

  op_e               op;
  logic [DATA_W-1:0] data_q;
  cap_src_e          src_q;
  logic [HOLD_W-1:0] hold_q;

  always_comb op = decode_op(shift_en, capt_en);

  cfg_scu_shift #(.DATA_W(DATA_W), .PREV_W(PREV_W), .HOLD_W(HOLD_W)) u_shift (
    .clk(clk), .rst(rst), .op(op), .ser_in(ser_in), .sel_wr(sel_wr),
    .sel_data(sel_data), .cur_state(cur_state), .prev_app1(prev_app1),
    .prev_app2(prev_app2), .hold_q(hold_q), .data_q(data_q), .src_q(src_q)
  );

  cfg_scu_hold #(.HOLD_W(HOLD_W)) u_hold (
    .clk(clk), .rst(rst), .op(op), .load_data(data_q[HOLD_W-1:0]), .hold_q(hold_q)
  );

  cfg_scu_imgsel u_img (
    .clk(clk), .rst(rst), .ovr_bit(hold_q[OVR_BIT]), .sel_bit(hold_q[SEL_BIT]),
    .pin_img_sel(pin_img_sel), .img_sel(img_sel), .img_ovr(img_ovr)
  );

  assign ser_out = data_q[0];

  // R1: bit 1 of the chain reaches the serial output after a shift
  a_r1_ser_advance: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> ser_out == $past(data_q[1]));

  // R2: shifting leaves hold register and selector untouched
  a_r2_hold_kept: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> $stable(hold_q));
  a_r2_src_kept: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> $stable(src_q));

  // R4: saved-word captures carry zero padding on top
  a_r4_pad_zero: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && capt_en && (src_q == SRC_PREV1 || src_q == SRC_PREV2))
      |=> data_q[DATA_W-1:PREV_W] == '0);

  // R5: reserved positions read back as zero
  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && capt_en && src_q == SRC_HOLD) |=> data_q[DATA_W-1:HOLD_W] == '0);

  // R6: selector strobe ignored during capture
  a_r6_no_sel_in_capture: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && capt_en) |=> $stable(src_q));

  // R7: decoded image select follows override bit or pin
  a_r7_override: assert property (@(posedge clk) disable iff (rst)
    hold_q[OVR_BIT] |=> img_sel == $past(hold_q[SEL_BIT]));
  a_r7_pin: assert property (@(posedge clk) disable iff (rst)
    !hold_q[OVR_BIT] |=> img_sel == $past(pin_img_sel));

endmodule

// File: tb/sim_cfg_scu_reg.sv
`timescale 1ns/1ps
module sim_cfg_scu_reg;

  localparam logic [38:0] CUR = 39'h4D_3C2B_1A09;
  localparam logic [30:0] P1  = 31'h2345_6789;
  localparam logic [30:0] P2  = 31'h7BCD_EF01;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shift_en = 1'b1, capt_en = 1'b0, ser_in = 1'b0, sel_wr = 1'b0;
  logic [1:0] sel_data = 2'b00;
  logic [38:0] cur_state = CUR;
  logic [30:0] prev_app1 = P1, prev_app2 = P2;
  logic pin_img_sel = 1'b0;
  logic ser_out, img_sel, img_ovr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cfg_scu_reg u0 (
    .clk(clk), .rst(rst), .shift_en(shift_en), .capt_en(capt_en), .ser_in(ser_in),
    .sel_wr(sel_wr), .sel_data(sel_data), .cur_state(cur_state),
    .prev_app1(prev_app1), .prev_app2(prev_app2), .pin_img_sel(pin_img_sel),
    .ser_out(ser_out), .img_sel(img_sel), .img_ovr(img_ovr)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    shift_en = 1'b1; capt_en = 1'b0; ser_in = 1'b0; sel_wr = 1'b0;
  endtask

  task automatic shift_in(input logic [38:0] d, input logic capt, input logic wr);
    for (int i = 0; i < 39; i++) begin
      shift_en = 1'b1; capt_en = capt; sel_wr = wr; sel_data = 2'b10; ser_in = d[i];
      step();
    end
    idle();
  endtask

  task automatic load_update(input logic [38:0] d, input logic [1:0] s);
    shift_in(d, 1'b0, 1'b0);
    shift_en = 1'b0; capt_en = 1'b0; sel_wr = 1'b1; sel_data = s;
    step();
    idle();
  endtask

  task automatic capture_read(output logic [38:0] v);
    shift_en = 1'b0; capt_en = 1'b1; sel_wr = 1'b0;
    step();
    for (int i = 0; i < 39; i++) begin
      v[i] = ser_out;
      idle();
      step();
    end
  endtask

  task automatic t_reset();
    logic [38:0] v;
    chk(ser_out == 1'b0, "R8 ser_out after reset", 64'(ser_out), 0);
    chk(img_sel == 1'b0 && img_ovr == 1'b0, "R8 image outputs after reset",
        64'({img_sel, img_ovr}), 0);
    capture_read(v);
    chk(v == CUR, "R8 selector resets to current-state source", 64'(v), 64'(CUR));
  endtask

  task automatic t_capture_sources();
    logic [38:0] v;
    logic [38:0] exp;
    for (int s = 0; s < 4; s++) begin
      load_update({39{1'b1}}, 2'(s));
      capture_read(v);
      case (s)
        0: exp = CUR;
        1: exp = {8'b0, P1};
        2: exp = {8'b0, P2};
        default: exp = {25'b0, 14'h3FFF};
      endcase
      chk(v == exp, $sformatf("R4 capture source %0d", s), 64'(v), 64'(exp));
    end
  endtask

  task automatic t_update_readback();
    logic [38:0] v;
    load_update(39'h55_AAAA_5A5A, 2'b11);
    capture_read(v);
    chk(v == {25'b0, 14'h1A5A}, "R3 R5 update then readback", 64'(v), 64'h1A5A);
  endtask

  task automatic t_shift_path();
    logic [38:0] v;
    logic [38:0] d = 39'h2B_9D4E_7316;
    load_update(39'h0000_1234, 2'b11);
    shift_in(d, 1'b1, 1'b1);
    for (int i = 0; i < 39; i++) begin
      v[i] = ser_out;
      shift_en = 1'b1; capt_en = 1'b1; ser_in = 1'b0;
      step();
    end
    idle();
    chk(v == d, "R1 serial path ignores capt_en", 64'(v), 64'(d));
    capture_read(v);
    chk(v == 39'h1234, "R2 hold and selector kept across shift", 64'(v), 64'h1234);
  endtask

  task automatic t_sel_strobe();
    logic [38:0] v;
    load_update(39'h0, 2'b00);
    shift_en = 1'b0; capt_en = 1'b1; sel_wr = 1'b1; sel_data = 2'b11;
    step();
    idle();
    capture_read(v);
    chk(v == CUR, "R6 strobe ignored in capture", 64'(v), 64'(CUR));
    for (int i = 0; i < 3; i++) begin
      shift_en = 1'b1; sel_wr = 1'b1; sel_data = 2'b01;
      step();
    end
    idle();
    capture_read(v);
    chk(v == CUR, "R6 strobe ignored in shift", 64'(v), 64'(CUR));
  endtask

  task automatic t_image();
    pin_img_sel = 1'b0;
    load_update(39'h3000, 2'b00);
    step();
    chk(img_sel == 1'b1 && img_ovr == 1'b1, "R7 override selects image 1",
        64'({img_sel, img_ovr}), 64'h3);
    pin_img_sel = 1'b1;
    load_update(39'h1000, 2'b00);
    step();
    chk(img_sel == 1'b0 && img_ovr == 1'b1, "R7 override beats pin",
        64'({img_sel, img_ovr}), 64'h1);
    pin_img_sel = 1'b0;
    load_update(39'h2000, 2'b00);
    step();
    chk(img_sel == 1'b0 && img_ovr == 1'b0, "R7 pin governs without override",
        64'({img_sel, img_ovr}), 64'h0);
    pin_img_sel = 1'b1;
    step();
    chk(img_sel == 1'b1, "R7 pin change one edge later", 64'(img_sel), 64'h1);
  endtask

  initial begin
    step(); step();
    chk(ser_out == 1'b0 && img_sel == 1'b0, "R8 outputs held in reset",
        64'({ser_out, img_sel}), 0);
    rst = 1'b0;
    t_reset();
    t_capture_sources();
    t_update_readback();
    t_shift_path();
    t_sel_strobe();
    t_image();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule